// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block watches the two request ports of a shared memory and decides which port may go ahead when both reach for the same word. Each port carries an enable, a write strobe, an output enable and a word address. When the two ports touch the same word in the same cycle and at least one of them writes, one port is held off. The block blocks that port's write and read grants at once. It also raises that port's busy flag, which is registered and so shows up one cycle later. Two ports that only read the same word never disturb each other.

Several of these blocks can be laid side by side to build a wider data word. One block runs as master and makes the decisions. The others run as slaves. A slave takes the master's busy flags on its inputs and uses them to gate its own grants, so every slice of the wide word obeys the same decision. The memory array itself sits outside this block and only takes the grant outputs.

Top module: `dpa_arbiter`

## Requirements
- R1: While reset is held and right after it is released, both busy outputs are 0.
- R2: If both ports are enabled on the same address and neither writes, neither port loses. Each port's read grant equals en & !wr & oe.
- R3: A collision means both ports are enabled, their addresses are equal, and at least one write strobe is 1. If neither port held that address in the previous cycle, the left port wins and the right port loses.
- R4: A port holds an address when it was enabled at that same address in the previous cycle. If exactly one colliding port holds the address, that port wins and the other loses. This applies to either side.
- R5: In master mode (master_sel=1), each busy output equals that port's loss decision from the previous cycle. The flag therefore falls one cycle after the winner disables or moves to another address.
- R6: A losing port gets write grant 0 and read grant 0 in the same cycle it loses. A port that does not lose gets write grant en & wr. It also gets read grant en & !wr & oe.
- R7: Ports on different addresses never lose.
- R8: In slave mode (master_sel=0), no local decision is made. A port's grants are blocked exactly when its busy input is 1, and both busy outputs stay 0.
- R9: Once a collision has a winner, that winner keeps winning for as long as both ports stay enabled on the same address and the collision lasts. This holds even if the write strobes change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| master_sel | input | 1 | 1 = master (local decision), 0 = slave (busy taken from inputs) |
| lt_en | input | 1 | Left port enable |
| lt_wr | input | 1 | Left port write strobe (1 = write, 0 = read) |
| lt_oe | input | 1 | Left port output enable |
| lt_addr | input | ADDR_W | Left port word address |
| rt_en | input | 1 | Right port enable |
| rt_wr | input | 1 | Right port write strobe |
| rt_oe | input | 1 | Right port output enable |
| rt_addr | input | ADDR_W | Right port word address |
| lt_busy_in | input | 1 | Left busy from the master; used only in slave mode |
| rt_busy_in | input | 1 | Right busy from the master; used only in slave mode |
| lt_busy_out | output | 1 | Left busy flag (registered) |
| rt_busy_out | output | 1 | Right busy flag (registered) |
| lt_wr_go | output | 1 | Left write grant to the memory |
| lt_rd_go | output | 1 | Left read grant to the memory |
| rt_wr_go | output | 1 | Right write grant to the memory |
| rt_rd_go | output | 1 | Right read grant to the memory |

## Verification
The assertions assume that master_sel changes only while reset is held. The bench drives each mode only inside its own reset window. The assertions also assume that every input is stable from just after one rising edge until past the next. The bench changes inputs one time unit after each edge to meet this. The random stimulus draws addresses from a pool of four words so that collisions, holds and releases occur often. The bench drives the slave busy inputs at random only in slave mode, because they have no effect in master mode.

// File: rtl/dpa_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the dual-port collision arbiter.
// Assumes nothing beyond being compiled before the modules that import it.
package dpa_pkg;
    // Result of one cycle's decision: no collision, left won, right won.
    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_LEFT  = 2'd1,
        WIN_RIGHT = 2'd2
    } win_e;

    localparam int NUM_SIDES = 2;
    localparam int SIDE_LT   = 0;
    localparam int SIDE_RT   = 1;
endpackage

// File: rtl/dpa_port_track.sv
`timescale 1ns/1ps
// Module: dpa_port_track
// Remembers one port's enable and address from the previous cycle. It
// reports whether the port still holds the same address this cycle.
// Assumes a synchronous active-low reset. A port counts as holding only
// if it was enabled in both cycles at an unchanged address.
module dpa_port_track #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hold
);
    logic              en_q;
    logic [ADDR_W-1:0] addr_q;

    // Capture last cycle's request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            en_q   <= en;
            addr_q <= addr;
        end
    end

    // Port keeps its address when it stays enabled at the same word.
    always_comb begin
        hold = en && en_q && (addr == addr_q);
    end

    // R4: a port that was idle last cycle cannot be holding
    a_r4_hold_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !hold || ($past(en) && $past(addr) == addr));
endmodule

// File: rtl/dpa_resolver.sv
`timescale 1ns/1ps
// Module: dpa_resolver
// Finds a collision between the two ports and picks a winner. A port
// that already holds the word beats a newcomer. On a tie the left port
// wins. A winner keeps winning while both ports keep the word.
// Assumes the hold inputs come from dpa_port_track for each side.
module dpa_resolver #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_hold,
    input  logic              r_en,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_hold,
    output logic              lose_l,
    output logic              lose_r
);
    import dpa_pkg::*;

    logic collide;
    logic keep_prev;
    win_e win_d;
    win_e win_q;

    // A collision needs both ports on one word with at least one writer.
    always_comb begin
        collide   = l_en && r_en && (l_addr == r_addr) && (l_wr || r_wr);
        keep_prev = (win_q != WIN_NONE) && l_hold && r_hold;
    end

    // Pick this cycle's winner: keep the old one, then the holder, then left.
    always_comb begin
        win_d = WIN_NONE;
        if (collide) begin
            if (keep_prev)
                win_d = win_q;
            else if (r_hold && !l_hold)
                win_d = WIN_RIGHT;
            else
                win_d = WIN_LEFT;
        end
    end

    // Remember the winner for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_q <= WIN_NONE;
        else
            win_q <= win_d;
    end

    // Turn the winner into per-side loss signals.
    always_comb begin
        lose_l = (win_d == WIN_RIGHT);
        lose_r = (win_d == WIN_LEFT);
    end

    // R2: two readers on the same word never lose
    a_r2_readers_free: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_wr && !r_wr) |-> (!lose_l && !lose_r));
    // R7: different words never collide
    a_r7_distinct_free: assert property (@(posedge clk) disable iff (!rst_n)
        (l_addr != r_addr) |-> (!lose_l && !lose_r));
    // R3: at most one side loses
    a_r3_single_loser: assert property (@(posedge clk) disable iff (!rst_n)
        !(lose_l && lose_r));
    // R9: a winner keeps winning while both sides keep the word
    a_r9_winner_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        lose_r ##1 (collide && l_hold && r_hold) |-> lose_r);
    a_r9_winner_sticks_rt: assert property (@(posedge clk) disable iff (!rst_n)
        lose_l ##1 (collide && l_hold && r_hold) |-> lose_l);
endmodule

// File: rtl/dpa_side_gate.sv
`timescale 1ns/1ps
// Module: dpa_side_gate
// One port's output stage. It chooses the blocking source by mode:
// the local loss in master mode, the busy input in slave mode. It gates
// the memory grants with that source and registers the busy flag.
// Assumes master_sel is static outside reset.
module dpa_side_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic master_sel,
    input  logic lose,
    input  logic busy_in,
    input  logic en,
    input  logic wr,
    input  logic oe,
    output logic busy_out,
    output logic wr_go,
    output logic rd_go
);
    logic block;
    logic busy_q;

    // Choose who may block this port.
    always_comb begin
        block = master_sel ? lose : busy_in;
    end

    // Grant memory access only to an unblocked port.
    always_comb begin
        wr_go = en && wr && !block;
        rd_go = en && !wr && oe && !block;
    end

    // Register the flag; only a master drives it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else
            busy_q <= master_sel && lose;
    end

    assign busy_out = busy_q;

    // R6: a losing master port gets no grant
    a_r6_loser_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && lose) |-> (!wr_go && !rd_go));
    // R8: a slave blocked by the master gets no grant
    a_r8_slave_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_sel && busy_in) |-> (!wr_go && !rd_go));
    // R5: the flag trails the loss by one cycle
    a_r5_flag_lag: assert property (@(posedge clk) disable iff (!rst_n)
        master_sel |=> (busy_out == $past(lose)));
    // R8: a slave never raises its own flag
    a_r8_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |=> !busy_out);
endmodule

// File: rtl/dpa_arbiter.sv
`timescale 1ns/1ps
// Module: dpa_arbiter (top)
// Collision arbiter for two ports of a shared memory. It tracks each
// port, makes one shared decision and gates each side's grants.
// Assumes synchronous active-low reset and master_sel static outside reset.
module dpa_arbiter #(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  logic              lt_en,
    input  logic              lt_wr,
    input  logic              lt_oe,
    input  logic [ADDR_W-1:0] lt_addr,
    input  logic              rt_en,
    input  logic              rt_wr,
    input  logic              rt_oe,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic              lt_busy_in,
    input  logic              rt_busy_in,
    output logic              lt_busy_out,
    output logic              rt_busy_out,
    output logic              lt_wr_go,
    output logic              lt_rd_go,
    output logic              rt_wr_go,
    output logic              rt_rd_go
);
    import dpa_pkg::*;

    logic [NUM_SIDES-1:0] en_v, wr_v, oe_v, hold_v, lose_v, bin_v;
    logic [NUM_SIDES-1:0] bout_v, wgo_v, rgo_v;
    logic [ADDR_W-1:0]    addr_v [NUM_SIDES];

    // Gather both sides into arrays for the per-side instances.
    always_comb begin
        en_v[SIDE_LT]   = lt_en;       en_v[SIDE_RT]   = rt_en;
        wr_v[SIDE_LT]   = lt_wr;       wr_v[SIDE_RT]   = rt_wr;
        oe_v[SIDE_LT]   = lt_oe;       oe_v[SIDE_RT]   = rt_oe;
        bin_v[SIDE_LT]  = lt_busy_in;  bin_v[SIDE_RT]  = rt_busy_in;
        addr_v[SIDE_LT] = lt_addr;     addr_v[SIDE_RT] = rt_addr;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        dpa_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (en_v[s]),
            .addr (addr_v[s]),
            .hold (hold_v[s])
        );

        dpa_side_gate u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .master_sel(master_sel),
            .lose      (lose_v[s]),
            .busy_in   (bin_v[s]),
            .en        (en_v[s]),
            .wr        (wr_v[s]),
            .oe        (oe_v[s]),
            .busy_out  (bout_v[s]),
            .wr_go     (wgo_v[s]),
            .rd_go     (rgo_v[s])
        );
    end

    dpa_resolver #(.ADDR_W(ADDR_W)) u_resolve (
        .clk   (clk),
        .rst_n (rst_n),
        .l_en  (lt_en),
        .l_wr  (lt_wr),
        .l_addr(lt_addr),
        .l_hold(hold_v[SIDE_LT]),
        .r_en  (rt_en),
        .r_wr  (rt_wr),
        .r_addr(rt_addr),
        .r_hold(hold_v[SIDE_RT]),
        .lose_l(lose_v[SIDE_LT]),
        .lose_r(lose_v[SIDE_RT])
    );

    assign lt_busy_out = bout_v[SIDE_LT];
    assign rt_busy_out = bout_v[SIDE_RT];
    assign lt_wr_go    = wgo_v[SIDE_LT];
    assign rt_wr_go    = wgo_v[SIDE_RT];
    assign lt_rd_go    = rgo_v[SIDE_LT];
    assign rt_rd_go    = rgo_v[SIDE_RT];

    // R1: flags are low in the first cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!lt_busy_out && !rt_busy_out));
endmodule

// File: tb/dpa_arbiter_test.sv
`timescale 1ns/1ps
module dpa_arbiter_test;
    localparam int AW = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_sel = 1'b1;
    logic lt_en = 0, lt_wr = 0, lt_oe = 0, rt_en = 0, rt_wr = 0, rt_oe = 0;
    logic [AW-1:0] lt_addr = '0, rt_addr = '0;
    logic lt_busy_in = 0, rt_busy_in = 0;
    logic lt_busy_out, rt_busy_out, lt_wr_go, lt_rd_go, rt_wr_go, rt_rd_go;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // Model state: the previous cycle's requests and the previous winner (0 none, 1 left, 2 right).
    logic          p_le = 0, p_re = 0;
    logic [AW-1:0] p_la = '0, p_ra = '0;
    logic [1:0]    p_win = 2'd0;

    always #2.5 clk = ~clk;

    dpa_arbiter #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
        .lt_en(lt_en), .lt_wr(lt_wr), .lt_oe(lt_oe), .lt_addr(lt_addr),
        .rt_en(rt_en), .rt_wr(rt_wr), .rt_oe(rt_oe), .rt_addr(rt_addr),
        .lt_busy_in(lt_busy_in), .rt_busy_in(rt_busy_in),
        .lt_busy_out(lt_busy_out), .rt_busy_out(rt_busy_out),
        .lt_wr_go(lt_wr_go), .lt_rd_go(lt_rd_go),
        .rt_wr_go(rt_wr_go), .rt_rd_go(rt_rd_go)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", tag, act, exp);
        end
    endtask

    // Winner per R3, R4 and R9, computed from the current inputs and the model state.
    function automatic logic [1:0] mdl_win();
        logic col, lh, rh;
        col = lt_en && rt_en && (lt_addr == rt_addr) && (lt_wr || rt_wr);
        lh  = lt_en && p_le && (lt_addr == p_la);
        rh  = rt_en && p_re && (rt_addr == p_ra);
        if (!col) return 2'd0;
        if (p_win != 2'd0 && lh && rh) return p_win;
        if (rh && !lh) return 2'd2;
        return 2'd1;
    endfunction

    task automatic step(input string tag,
                        input logic le, lw, lo, input logic [AW-1:0] la,
                        input logic re, rw, ro, input logic [AW-1:0] ra,
                        input logic bl = 0, input logic br = 0);
        logic [1:0] w;
        logic bkl, bkr;
        lt_en = le; lt_wr = lw; lt_oe = lo; lt_addr = la;
        rt_en = re; rt_wr = rw; rt_oe = ro; rt_addr = ra;
        lt_busy_in = bl; rt_busy_in = br;
        #1;
        w = mdl_win();
        bkl = master_sel ? (w == 2'd2) : bl;
        bkr = master_sel ? (w == 2'd1) : br;
        chk({tag, " R6 lt_wr_go"}, lt_wr_go, le && lw && !bkl);
        chk({tag, " R6 lt_rd_go"}, lt_rd_go, le && !lw && lo && !bkl);
        chk({tag, " R6 rt_wr_go"}, rt_wr_go, re && rw && !bkr);
        chk({tag, " R6 rt_rd_go"}, rt_rd_go, re && !rw && ro && !bkr);
        @(posedge clk);
        #1;
        p_le = le; p_la = la; p_re = re; p_ra = ra; p_win = w;
        chk({tag, " R5 lt_busy_out"}, lt_busy_out, master_sel && (w == 2'd2));
        chk({tag, " R5 rt_busy_out"}, rt_busy_out, master_sel && (w == 2'd1));
    endtask

    task automatic do_reset(input logic mode);
        rst_n = 0; master_sel = mode;
        lt_en = 0; rt_en = 0; lt_wr = 0; rt_wr = 0; lt_busy_in = 0; rt_busy_in = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 lt_busy_out in reset", lt_busy_out, 1'b0);
        chk("R1 rt_busy_out in reset", rt_busy_out, 1'b0);
        rst_n = 1;
        p_le = 0; p_re = 0; p_win = 2'd0;
    endtask

    initial begin
        process::self().srandom(32'd1234);
        do_reset(1'b1);
        // R2: both read word 3
        step("R2 rr", 1,0,1,14'd3, 1,0,1,14'd3);
        step("R2 rr hold", 1,0,1,14'd3, 1,0,1,14'd3);
        // R9: right starts writing while both hold; tie goes to left
        step("R9 held tie", 1,0,1,14'd3, 1,1,0,14'd3);
        step("R9 keep", 1,1,0,14'd3, 1,1,0,14'd3);
        step("R5 release", 0,0,0,14'd3, 1,1,0,14'd3);
        chk("R5 drop after release", rt_busy_out, 1'b0);
        step("idle", 0,0,0,0, 0,0,0,0);
        // R3: simultaneous write/write
        step("R3 ww tie", 1,1,0,14'h3FFF, 1,1,0,14'h3FFF);
        chk("R3 rt flagged", rt_busy_out, 1'b1);
        step("R9 ww keep", 1,1,0,14'h3FFF, 1,1,0,14'h3FFF);
        step("R5 move", 1,1,0,14'h0001, 1,1,0,14'h3FFF);
        step("idle", 0,0,0,0, 0,0,0,0);
        // R3: left reads, right writes at once
        step("R3 rw tie", 1,0,1,14'd9, 1,1,0,14'd9);
        step("idle", 0,0,0,0, 0,0,0,0);
        // R4: right holds, left arrives
        step("R4 rt alone", 0,0,0,14'd9, 1,0,1,14'd9);
        step("R4 lt newcomer", 1,1,0,14'd9, 1,0,1,14'd9);
        chk("R4 lt flagged", lt_busy_out, 1'b1);
        step("R5 rt release", 1,1,0,14'd9, 0,0,0,14'd9);
        chk("R5 lt flag drops", lt_busy_out, 1'b0);
        // R4: left holds, right arrives
        step("R4 lt holds", 1,1,0,14'd9, 1,1,0,14'd9);
        // R7: distinct words
        step("R7 distinct", 1,1,0,14'd20, 1,1,0,14'd21);
        step("R7 distinct2", 1,1,0,14'd21, 1,1,0,14'd20);
        // random master traffic on a small address pool
        for (int i = 0; i < 600; i++) begin
            step("random R4", 1'($urandom), 1'($urandom), 1'($urandom), 14'($urandom % 4),
                 1'($urandom), 1'($urandom), 1'($urandom), 14'($urandom % 4));
        end
        // R8: slave mode
        do_reset(1'b0);
        step("R8 slave ww", 1,1,0,14'd5, 1,1,0,14'd5, 0, 0);
        step("R8 slave blk lt", 1,1,0,14'd5, 1,1,0,14'd5, 1, 0);
        step("R8 slave blk rt", 1,0,1,14'd5, 1,0,1,14'd6, 0, 1);
        for (int i = 0; i < 300; i++) begin
            step("random R8", 1'($urandom), 1'($urandom), 1'($urandom), 14'($urandom % 4),
                 1'($urandom), 1'($urandom), 1'($urandom), 14'($urandom % 4),
                 1'($urandom), 1'($urandom));
        end
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule